// File: doc/BRIEF.md
# Packed Rounding-Average Vector Unit

This block takes two packed vectors of unsigned integers and returns, lane by lane, their average rounded upward at the half: (a + b + 1) >> 1. One adder chain serves both lane sizes. A select input sets whether the vector is split into 8-bit lanes or 16-bit lanes. In 16-bit mode, the carry out of each low byte feeds the high byte of the same word. In 8-bit mode, every byte gets its own rounding carry-in. Each lane keeps one extra carry bit, so the halved result always fits back into its lane and nothing spills into a neighbour.

A per-lane writemask chooses which lanes take the new average. A lane that is not selected either keeps the matching lane of the supplied old destination (merge) or is forced to zero (zeroing), under a single flag. When the mask-enable input is low, every lane is written whatever the mask holds. The result is registered. Output valid follows input valid one clock later, and the output data holds when no new operation is presented. The vector width is a parameter from 64 to 512 bits, and must be a multiple of 16.

Top module: `pavg_unit`

## Requirements
- R1: With `lane_word` = 0, each output byte i is (A_i + B_i + 1) >> 1, with both bytes taken as unsigned values 0..255.
- R2: With `lane_word` = 1, each output 16-bit word i is (A_i + B_i + 1) >> 1, with both words taken as unsigned values 0..65535.
- R3: No lane result wraps and no carry crosses a lane boundary. 0xFF with 0xFF gives 0xFF, 0xFF with 0x00 gives 0x80, 0x00 with 0x01 gives 0x01, and in word mode 0xFFFF with 0xFFFF gives 0xFFFF.
- R4: With `mask_on` = 1, mask bit i governs byte lane i in byte mode and word lane i in word mode. In word mode, mask bits at index VEC_W/16 and above have no effect.
- R5: With `mask_on` = 0, every lane takes the average, whatever `wmask` holds.
- R6: With `zero_fill` = 0, a lane whose mask bit is 0 outputs the matching lane of `old_dst`.
- R7: With `zero_fill` = 1, a lane whose mask bit is 0 outputs zero.
- R8: `out_valid` equals `in_valid` of the previous clock. A synchronous active-high `rst` clears both `out_valid` and `out_data`.
- R9: In a clock where `in_valid` is 0, `out_data` does not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| lane_word | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| op_a | input | VEC_W | First packed operand |
| op_b | input | VEC_W | Second packed operand |
| old_dst | input | VEC_W | Prior destination value used for merging |
| wmask | input | VEC_W/8 | Per-lane write mask |
| mask_on | input | 1 | 1: apply wmask, 0: write all lanes |
| zero_fill | input | 1 | 1: clear unselected lanes, 0: merge them |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_data | output | VEC_W | Registered result vector |

## Verification
Two functions can meet in the same cycle. One is the carry that links the two bytes of a word in 16-bit mode. The other is the per-byte select between the average, the old destination and zero. In word mode the mask must act on whole words, so both halves of a carry-linked word must make the same choice. The bench provokes this with back-to-back word-mode operations whose low bytes carry and whose mask bits change from word to word, including upper mask bits that should be ignored. Each output word is judged against a bench model that works on whole 16-bit integers.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

  typedef enum logic {
    LANE_B8  = 1'b0,
    LANE_W16 = 1'b1
  } lane_sz_e;

  // Reference arithmetic: rounded unsigned average of one 8-bit lane.
  function automatic logic [7:0] ravg8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  // Reference arithmetic: rounded unsigned average of one 16-bit lane.
  function automatic logic [15:0] ravg16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b} + 17'd1;
    return s[16:1];
  endfunction

endpackage

// File: rtl/pavg_byte_slice.sv
module pavg_byte_slice (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  output logic [7:0] sum,
  output logic       cout
);
  logic [8:0] s9;

  always_comb begin
    s9   = {1'b0, a} + {1'b0, b} + {8'd0, cin};
    sum  = s9[7:0];
    cout = s9[8];
  end
endmodule

// File: rtl/pavg_chain.sv
module pavg_chain #(
  parameter int VEC_W = 128,
  localparam int NB   = VEC_W / 8
) (
  input  logic             lane_word,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic [VEC_W-1:0] avg_res,
  output logic [NB-1:0]    avg_carry
);
  import pavg_pkg::*;

  lane_sz_e          sz;
  logic [NB-1:0]     cin;
  logic [7:0]        part [NB];

  assign sz = lane_sz_e'(lane_word);

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic top;

    if (j % 2 == 1) begin : g_hi
      // High byte of a word: linked to the low byte in 16-bit mode.
      assign cin[j] = (sz == LANE_W16) ? avg_carry[j-1] : 1'b1;
      assign top    = avg_carry[j];
    end else begin : g_lo
      // Low byte always takes the rounding carry-in.
      assign cin[j] = 1'b1;
      assign top    = (sz == LANE_W16) ? part[j+1][0] : avg_carry[j];
    end

    pavg_byte_slice u_slice (
      .a    (op_a[8*j +: 8]),
      .b    (op_b[8*j +: 8]),
      .cin  (cin[j]),
      .sum  (part[j]),
      .cout (avg_carry[j])
    );

    assign avg_res[8*j +: 8] = {top, part[j][7:1]};
  end
endmodule

// File: rtl/pavg_lane_enable.sv
module pavg_lane_enable #(
  parameter int VEC_W = 128,
  localparam int NB   = VEC_W / 8
) (
  input  logic          lane_word,
  input  logic          mask_on,
  input  logic [NB-1:0] wmask,
  output logic [NB-1:0] byte_wen
);
  import pavg_pkg::*;

  lane_sz_e sz;
  assign sz = lane_sz_e'(lane_word);

  for (genvar j = 0; j < NB; j++) begin : g_en
    logic sel;
    assign sel         = (sz == LANE_W16) ? wmask[j/2] : wmask[j];
    assign byte_wen[j] = !mask_on || sel;
  end
endmodule

// File: rtl/pavg_writeback.sv
module pavg_writeback #(
  parameter int VEC_W = 128,
  localparam int NB   = VEC_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             zero_fill,
  input  logic [NB-1:0]    byte_wen,
  input  logic [VEC_W-1:0] avg_res,
  input  logic [VEC_W-1:0] old_dst,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  logic [VEC_W-1:0] nxt;

  for (genvar j = 0; j < NB; j++) begin : g_sel
    assign nxt[8*j +: 8] = byte_wen[j] ? avg_res[8*j +: 8]
                         : (zero_fill ? 8'h00 : old_dst[8*j +: 8]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/pavg_unit.sv
module pavg_unit #(
  parameter int VEC_W = 128,
  localparam int NB   = VEC_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             lane_word,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [NB-1:0]    wmask,
  input  logic             mask_on,
  input  logic             zero_fill,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  // Named internal events, visible to the bound checker.
  logic [VEC_W-1:0] avg_res;
  logic [NB-1:0]    avg_carry;
  logic [NB-1:0]    byte_wen;

  pavg_chain #(.VEC_W(VEC_W)) u_chain (
    .lane_word (lane_word),
    .op_a      (op_a),
    .op_b      (op_b),
    .avg_res   (avg_res),
    .avg_carry (avg_carry)
  );

  pavg_lane_enable #(.VEC_W(VEC_W)) u_en (
    .lane_word (lane_word),
    .mask_on   (mask_on),
    .wmask     (wmask),
    .byte_wen  (byte_wen)
  );

  pavg_writeback #(.VEC_W(VEC_W)) u_wb (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .zero_fill (zero_fill),
    .byte_wen  (byte_wen),
    .avg_res   (avg_res),
    .old_dst   (old_dst),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/pavg_unit_chk.sv
module pavg_unit_chk #(
  parameter int VEC_W = 128,
  localparam int NB   = VEC_W / 8,
  localparam int NW   = VEC_W / 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             lane_word,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic [VEC_W-1:0] old_dst,
  input logic [NB-1:0]    wmask,
  input logic             mask_on,
  input logic             zero_fill,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data,
  input logic [NB-1:0]    byte_wen
);
  import pavg_pkg::*;

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_all_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    !mask_on |-> (&byte_wen));

  assert_byte_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (mask_on && !lane_word) |-> (byte_wen == wmask));

  for (genvar j = 0; j < NB; j++) begin : g_b
    assert_avg8_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !lane_word && byte_wen[j]) |=>
        out_data[8*j +: 8] == ravg8($past(op_a[8*j +: 8]), $past(op_b[8*j +: 8])));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !lane_word && byte_wen[j]) |=>
        ((out_data[8*j +: 8] >= $past(op_a[8*j +: 8])) ||
         (out_data[8*j +: 8] >= $past(op_b[8*j +: 8]))) &&
        ((out_data[8*j +: 8] <= $past(op_a[8*j +: 8])) ||
         (out_data[8*j +: 8] <= $past(op_b[8*j +: 8]))));

    assert_merge_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !zero_fill && !byte_wen[j]) |=>
        out_data[8*j +: 8] == $past(old_dst[8*j +: 8]));

    assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && zero_fill && !byte_wen[j]) |=> out_data[8*j +: 8] == 8'h00);
  end

  for (genvar w = 0; w < NW; w++) begin : g_w
    assert_word_pair_R4: assert property (@(posedge clk) disable iff (rst)
      lane_word |-> (byte_wen[2*w] == byte_wen[2*w+1]));

    assert_avg16_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_word && byte_wen[2*w]) |=>
        out_data[16*w +: 16] == ravg16($past(op_a[16*w +: 16]), $past(op_b[16*w +: 16])));
  end
endmodule

bind pavg_unit pavg_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .lane_word (lane_word),
  .op_a      (op_a),
  .op_b      (op_b),
  .old_dst   (old_dst),
  .wmask     (wmask),
  .mask_on   (mask_on),
  .zero_fill (zero_fill),
  .out_valid (out_valid),
  .out_data  (out_data),
  .byte_wen  (byte_wen)
);

// File: tb/pavg_unit_bench.sv
module pavg_unit_bench;
  localparam int VW = 128;
  localparam int NB = VW / 8;
  localparam int NW = VW / 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          lane_word = 1'b0;
  logic [VW-1:0] op_a = '0, op_b = '0, old_dst = '0;
  logic [NB-1:0] wmask = '0;
  logic          mask_on = 1'b0;
  logic          zero_fill = 1'b0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pavg_unit #(.VEC_W(VW)) u_pavg_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_word(lane_word),
    .op_a(op_a), .op_b(op_b), .old_dst(old_dst), .wmask(wmask),
    .mask_on(mask_on), .zero_fill(zero_fill),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Bench model: whole-integer average per lane, then mask policy.
  function automatic logic [VW-1:0] model(
    input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] od,
    input logic [NB-1:0] m, input logic me, input logic zf, input logic wd);
    logic [VW-1:0] r;
    int lw, nl, x, y;
    lw = wd ? 16 : 8;
    nl = VW / lw;
    r  = '0;
    for (int i = 0; i < nl; i++) begin
      if (!me || m[i]) begin
        x = wd ? int'(a[16*i +: 16]) : int'(a[8*i +: 8]);
        y = wd ? int'(b[16*i +: 16]) : int'(b[8*i +: 8]);
        x = (x + y + 1) / 2;
        if (wd) r[16*i +: 16] = x[15:0]; else r[8*i +: 8] = x[7:0];
      end else if (!zf) begin
        if (wd) r[16*i +: 16] = od[16*i +: 16]; else r[8*i +: 8] = od[8*i +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a negedge: present one operation, check it at the next negedge.
  task automatic op(input string tag, input logic [VW-1:0] a, input logic [VW-1:0] b,
                    input logic [VW-1:0] od, input logic [NB-1:0] m,
                    input logic me, input logic zf, input logic wd);
    logic [VW-1:0] e;
    in_valid = 1'b1; op_a = a; op_b = b; old_dst = od; wmask = m;
    mask_on = me; zero_fill = zf; lane_word = wd;
    e = model(a, b, od, m, me, zf, wd);
    @(negedge clk);
    check({tag, " data"}, out_data, e);
    check("R8 valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
  endtask

  function automatic logic [VW-1:0] rvec(input int bias);
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[32*k +: 32] = $urandom;
    if (bias == 1) for (int k = 0; k < NB; k++) if (v[8*k]) v[8*k +: 8] = 8'hFF;
    if (bias == 2) for (int k = 0; k < NB; k++) if (v[8*k+1]) v[8*k +: 8] = 8'h00;
    return v;
  endfunction

  initial begin
    logic [VW-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 reset data", out_data, '0);
    check("R8 reset valid", {{(VW-1){1'b0}}, out_valid}, '0);
    rst = 1'b0;

    // R3 corners
    op("R3 ff+ff", {NB{8'hFF}}, {NB{8'hFF}}, '0, '0, 1'b0, 1'b0, 1'b0);
    if (out_data !== {NB{8'hFF}}) check("R3 ff+ff literal", out_data, {NB{8'hFF}});
    op("R3 ff+00", {NB{8'hFF}}, '0, '0, '0, 1'b0, 1'b0, 1'b0);
    check("R3 ff+00 literal", out_data, {NB{8'h80}});
    op("R3 00+01", '0, {NB{8'h01}}, '0, '0, 1'b0, 1'b0, 1'b0);
    check("R3 00+01 literal", out_data, {NB{8'h01}});
    op("R3 ffff+ffff", {NW{16'hFFFF}}, {NW{16'hFFFF}}, '0, '0, 1'b0, 1'b0, 1'b1);
    check("R3 ffff literal", out_data, {NW{16'hFFFF}});
    // R2: carry from low byte into high byte in word mode
    op("R2 link", {NW{16'h01FF}}, {NW{16'h0001}}, '0, '0, 1'b0, 1'b0, 1'b1);
    check("R2 link literal", out_data, {NW{16'h0100}});
    // R1: same data in byte mode gives separate lanes
    op("R1 split", {NW{16'h01FF}}, {NW{16'h0001}}, '0, '0, 1'b0, 1'b0, 1'b0);
    check("R1 split literal", out_data, {NW{16'h0180}});
    // R5: mask off, mask value ignored
    op("R5 unmasked", {NB{8'h10}}, {NB{8'h20}}, {NB{8'hAA}}, '0, 1'b0, 1'b1, 1'b0);
    check("R5 literal", out_data, {NB{8'h18}});
    // R6 merge / R7 zero with alternating mask
    op("R6 merge", {NB{8'h10}}, {NB{8'h20}}, {NB{8'hAA}}, {(NB/2){2'b01}}, 1'b1, 1'b0, 1'b0);
    check("R6 literal", out_data, {(NB/2){16'hAA18}});
    op("R7 zero", {NB{8'h10}}, {NB{8'h20}}, {NB{8'hAA}}, {(NB/2){2'b01}}, 1'b1, 1'b1, 1'b0);
    check("R7 literal", out_data, {(NB/2){16'h0018}});
    // R4: word mode, only upper mask bits set -> all words merged
    op("R4 upper ignored", {NW{16'h1234}}, {NW{16'h5678}}, {NW{16'hBEEF}},
       {{(NB-NW){1'b1}}, {NW{1'b0}}}, 1'b1, 1'b0, 1'b1);
    check("R4 literal", out_data, {NW{16'hBEEF}});

    // R9: hold while in_valid is low
    held = out_data;
    in_valid = 1'b0; op_a = rvec(0); op_b = rvec(0); old_dst = rvec(0);
    @(negedge clk);
    check("R9 hold", out_data, held);
    check("R8 valid low", {{(VW-1){1'b0}}, out_valid}, '0);

    // Random back-to-back mix: R1 R2 R4 R5 R6 R7
    for (int t = 0; t < 400; t++) begin
      logic [NB-1:0] m;
      m = NB'($urandom);
      op("R1 R2 R4 R5 R6 R7 random", rvec(t % 3), rvec((t + 1) % 3), rvec(0), m,
         1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R8: reset mid-stream clears
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset", out_data, '0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule